// File: doc/BRIEF.md
# D-Channel Loopback and Echo-Check Controller

This block sits between a serial subscriber-line interface and a data link controller. Once per D-bit time, marked by a bit-clock enable, it decides where the D-channel bits go. It chooses what the line transmit bit carries and what the link controller receives. While a frame is being sent on the line, it also compares the bit it sent with the echo bit returned by the network. In normal operation a difference between the two stops the frame: the block raises a one-cycle halt pulse and forces the line to the idle value of 1.

A 3-bit mode field selects the routing:
- `mode[0]` enables a remote loop. Line D bits pass through the link controller and go back to the line, and local transmit requests are ignored.
- `mode[1]` enables a local loop. The line is held idle, and the local transmit data returns to the receive path. This loop wins over `mode[0]`.
- `mode[2]` keeps normal routing but suppresses the halt.

The field is sampled at each bit time, together with the data inputs.

Top module: `dch_loop_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `line_d_tx` = 1, `dlc_rx_bit` = 1 and `halt` = 0.
- R2: With `mode[1:0]` = 00, at each `bit_en` edge the block loads two values, both visible on the following cycle. `line_d_tx` takes `dlc_tx_bit` when `up_tx_req` and `dlc_tx_vld` are both high and no halt is in effect; otherwise it takes 1. `dlc_rx_bit` takes `line_d_rx`.
- R3: With `mode` = 000, suppose a frame bit was driven on `line_d_tx` at the previous bit time. If `line_e_rx` differs from it at the current `bit_en` edge, `halt` is 1 on the following cycle.
- R4: In the cycle `halt` is 1, `line_d_tx` is 1. It stays 1 at every bit time until `up_tx_req` has been low for at least one clock.
- R5: With `mode[2]` = 1, echo mismatches never raise `halt`, and `line_d_tx` keeps following `dlc_tx_bit`.
- R6: With `mode[0]` = 1 and `mode[1]` = 0, at each `bit_en` edge both `line_d_tx` and `dlc_rx_bit` take `line_d_rx`. `up_tx_req`, `dlc_tx_bit` and `dlc_tx_vld` have no effect, and `halt` stays 0.
- R7: With `mode[1]` = 1 (whatever `mode[0]` is), at each `bit_en` edge `line_d_tx` takes 1. `dlc_rx_bit` takes `dlc_tx_bit` when `up_tx_req` and `dlc_tx_vld` are high, and 1 otherwise. `line_d_rx` has no effect, and `halt` stays 0.
- R8: On cycles where `bit_en` was low at the previous edge, `line_d_tx` and `dlc_rx_bit` keep their values.
- R9: `halt` is never high for two consecutive cycles, and at most one halt occurs per frame. A frame runs from `up_tx_req` rising to `up_tx_req` falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per D-bit time |
| mode | input | 3 | bit0 remote loop, bit1 local loop, bit2 halt suppress |
| line_d_rx | input | 1 | D bit received from the line |
| line_e_rx | input | 1 | Echo bit received from the line |
| dlc_tx_bit | input | 1 | Transmit bit from the link controller |
| dlc_tx_vld | input | 1 | `dlc_tx_bit` carries frame data |
| up_tx_req | input | 1 | Local side requests/holds a transmit frame |
| line_d_tx | output | 1 | D bit driven to the line |
| dlc_rx_bit | output | 1 | Bit delivered to the link controller receive path |
| halt | output | 1 | One-cycle frame abort pulse |

## Verification
Suppose the armed flag, the halted latch or the stored line bit holds a wrong value. The fault shows at the ports no later than the cycle after the next `bit_en` edge. It appears as a missing or extra `halt` pulse, or as `line_d_tx` carrying data when it should be idle (or idle when it should carry data). A wrong route decode shows up as `line_d_tx` or `dlc_rx_bit` following the wrong source on the first bit time after a mode change. Injected echo mismatches under all eight mode values decide whether the halt path is masked correctly in each one.

// File: rtl/dch_loop_pkg.sv
package dch_loop_pkg;

    localparam int MODE_W       = 3;
    localparam int MB_REMOTE    = 0;
    localparam int MB_LOCAL     = 1;
    localparam int MB_NOBACKOFF = 2;
    localparam logic IDLE_BIT   = 1'b1;

    typedef enum logic [1:0] {
        RT_NORMAL = 2'd0,
        RT_REMOTE = 2'd1,
        RT_LOCAL  = 2'd2
    } route_e;

    typedef struct packed {
        logic d_tx;
        logic rx;
    } lane_t;

    function automatic route_e pick_route(input logic [MODE_W-1:0] m);
        if (m[MB_LOCAL])
            return RT_LOCAL;
        else if (m[MB_REMOTE])
            return RT_REMOTE;
        return RT_NORMAL;
    endfunction

    function automatic logic halt_masked(input logic [MODE_W-1:0] m);
        return |m;
    endfunction

endpackage

// File: rtl/dch_route.sv
module dch_route
    import dch_loop_pkg::*;
(
    input  route_e route,
    input  logic   sending,
    input  logic   tx_ok,
    input  logic   dlc_tx_bit,
    input  logic   line_d_rx,
    output lane_t  nxt
);
    always_comb begin
        nxt.d_tx = IDLE_BIT;
        nxt.rx   = IDLE_BIT;
        case (route)
            RT_NORMAL: begin
                nxt.d_tx = (sending && tx_ok) ? dlc_tx_bit : IDLE_BIT;
                nxt.rx   = line_d_rx;
            end
            RT_REMOTE: begin
                nxt.d_tx = line_d_rx;
                nxt.rx   = line_d_rx;
            end
            RT_LOCAL: begin
                nxt.d_tx = IDLE_BIT;
                nxt.rx   = sending ? dlc_tx_bit : IDLE_BIT;
            end
            default: begin
                nxt.d_tx = IDLE_BIT;
                nxt.rx   = IDLE_BIT;
            end
        endcase
    end
endmodule

// File: rtl/dch_echo.sv
module dch_echo (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic mask,
    input  logic route_normal,
    input  logic sending,
    input  logic up_tx_req,
    input  logic line_e_rx,
    input  logic cur_d_tx,
    output logic halt_now,
    output logic halted_q,
    output logic halt_q
);
    logic armed_q;

    assign halt_now = bit_en && armed_q && (line_e_rx != cur_d_tx) && !mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            halted_q <= 1'b0;
            halt_q   <= 1'b0;
        end else begin
            if (bit_en)
                armed_q <= route_normal && sending && !halted_q && !halt_now;
            halted_q <= halt_now || (halted_q && up_tx_req);
            halt_q   <= halt_now;
        end
    end
endmodule

// File: rtl/dch_lane_reg.sv
module dch_lane_reg
    import dch_loop_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_en,
    input  lane_t nxt,
    output lane_t cur
);
    always_ff @(posedge clk) begin
        if (rst)
            cur <= '{d_tx: IDLE_BIT, rx: IDLE_BIT};
        else if (bit_en)
            cur <= nxt;
    end
endmodule

// File: rtl/dch_loop_ctrl.sv
module dch_loop_ctrl
    import dch_loop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic [MODE_W-1:0] mode,
    input  logic              line_d_rx,
    input  logic              line_e_rx,
    input  logic              dlc_tx_bit,
    input  logic              dlc_tx_vld,
    input  logic              up_tx_req,
    output logic              line_d_tx,
    output logic              dlc_rx_bit,
    output logic              halt
);
    route_e route;
    lane_t  nxt_lane;
    lane_t  cur_lane;
    logic   sending;
    logic   halt_now;
    logic   halted_q;
    logic   halt_q;

    assign route   = pick_route(mode);
    assign sending = up_tx_req && dlc_tx_vld;

    dch_echo u_echo (
        .clk          (clk),
        .rst          (rst),
        .bit_en       (bit_en),
        .mask         (halt_masked(mode)),
        .route_normal (route == RT_NORMAL),
        .sending      (sending),
        .up_tx_req    (up_tx_req),
        .line_e_rx    (line_e_rx),
        .cur_d_tx     (cur_lane.d_tx),
        .halt_now     (halt_now),
        .halted_q     (halted_q),
        .halt_q       (halt_q)
    );

    dch_route u_route (
        .route      (route),
        .sending    (sending),
        .tx_ok      (!halted_q && !halt_now),
        .dlc_tx_bit (dlc_tx_bit),
        .line_d_rx  (line_d_rx),
        .nxt        (nxt_lane)
    );

    dch_lane_reg u_lane (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .nxt    (nxt_lane),
        .cur    (cur_lane)
    );

    assign line_d_tx  = cur_lane.d_tx;
    assign dlc_rx_bit = cur_lane.rx;
    assign halt       = halt_q;
endmodule

// File: rtl/dch_loop_chk.sv
module dch_loop_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic [2:0] mode,
    input logic       line_d_rx,
    input logic       line_d_tx,
    input logic       dlc_rx_bit,
    input logic       halt
);
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(line_d_tx) && $stable(dlc_rx_bit)));

    assert_halt_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        halt |=> !halt);

    assert_idle_after_halt_R4: assert property (@(posedge clk) disable iff (rst)
        halt |-> line_d_tx);

    assert_masked_no_halt_R5: assert property (@(posedge clk) disable iff (rst)
        (bit_en && (mode != 3'b000)) |=> !halt);

    assert_remote_echo_R6: assert property (@(posedge clk) disable iff (rst)
        (bit_en && mode[0] && !mode[1]) |=> (line_d_tx == $past(line_d_rx)));

    assert_local_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (bit_en && mode[1]) |=> line_d_tx);

    assert_normal_rx_R2: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !mode[1]) |=> (dlc_rx_bit == $past(line_d_rx)));
endmodule

bind dch_loop_ctrl dch_loop_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .mode       (mode),
    .line_d_rx  (line_d_rx),
    .line_d_tx  (line_d_tx),
    .dlc_rx_bit (dlc_rx_bit),
    .halt       (halt)
);

// File: tb/dch_loop_ctrl_tb.sv
module dch_loop_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic [2:0] mode = 3'b000;
    logic       line_d_rx = 1'b1;
    logic       line_e_rx = 1'b1;
    logic       dlc_tx_bit = 1'b1;
    logic       dlc_tx_vld = 1'b0;
    logic       up_tx_req = 1'b0;
    logic       line_d_tx;
    logic       dlc_rx_bit;
    logic       halt;

    int    checks = 0;
    int    failures = 0;
    int    halts_seen = 0;
    bit    done = 1'b0;
    bit    prev_halt = 1'b0;
    string cur_req = "R1";

    logic m_tx = 1'b1, m_rx = 1'b1, m_halt = 1'b0;
    bit   m_stopped = 1'b0;
    bit   m_watch = 1'b0;

    always #2 clk = ~clk;

    dch_loop_ctrl u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .mode(mode),
        .line_d_rx(line_d_rx), .line_e_rx(line_e_rx),
        .dlc_tx_bit(dlc_tx_bit), .dlc_tx_vld(dlc_tx_vld),
        .up_tx_req(up_tx_req), .line_d_tx(line_d_tx),
        .dlc_rx_bit(dlc_rx_bit), .halt(halt)
    );

    // behavioural reference, one evaluation per rising edge
    always @(posedge clk) begin
        bit   stop_now;
        bit   frame_bit;
        stop_now  = 1'b0;
        frame_bit = up_tx_req && dlc_tx_vld;
        if (rst) begin
            m_tx = 1'b1; m_rx = 1'b1; m_halt = 1'b0;
            m_stopped = 1'b0; m_watch = 1'b0;
        end else begin
            if (bit_en) begin
                if (m_watch && (line_e_rx !== m_tx) && (mode == 3'b000))
                    stop_now = 1'b1;
                if (mode[1]) begin
                    m_tx = 1'b1;
                    m_rx = frame_bit ? dlc_tx_bit : 1'b1;
                    m_watch = 1'b0;
                end else if (mode[0]) begin
                    m_tx = line_d_rx;
                    m_rx = line_d_rx;
                    m_watch = 1'b0;
                end else begin
                    m_watch = frame_bit && !m_stopped && !stop_now;
                    m_tx = m_watch ? dlc_tx_bit : 1'b1;
                    m_rx = line_d_rx;
                end
            end
            m_halt = stop_now;
            m_stopped = stop_now || (m_stopped && up_tx_req);
        end
    end

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(cur_req, "line_d_tx", line_d_tx, m_tx);
            check(cur_req, "dlc_rx_bit", dlc_rx_bit, m_rx);
            check(cur_req, "halt", halt, m_halt);
            if (halt) halts_seen++;
            if (halt && prev_halt) check("R9", "halt width", 1'b1, 1'b0);
            prev_halt = halt;
        end
    end

    // one D-bit time: strobe cycle then three quiet cycles with toggled inputs (R8)
    task automatic step(input logic b, input logic vld, input logic up,
                        input logic drx, input logic inj);
        @(negedge clk);
        bit_en = 1'b1; dlc_tx_bit = b; dlc_tx_vld = vld;
        up_tx_req = up; line_d_rx = drx;
        line_e_rx = inj ? ~m_tx : m_tx;
        @(negedge clk);
        bit_en = 1'b0; dlc_tx_bit = ~b; line_d_rx = ~drx; line_e_rx = ~line_e_rx;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic frame(input int nbits, input int inj_at, input logic [15:0] pat,
                         input logic [15:0] rxpat);
        for (int i = 0; i < nbits; i++)
            step(pat[i], 1'b1, 1'b1, rxpat[i], (i == inj_at));
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset line_d_tx", line_d_tx, 1'b1);
        check("R1", "reset dlc_rx_bit", dlc_rx_bit, 1'b1);
        check("R1", "reset halt", halt, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "post-reset line_d_tx", line_d_tx, 1'b1);
        check("R1", "post-reset halt", halt, 1'b0);

        cur_req = "R2";
        mode = 3'b000;
        halts_seen = 0;
        frame(12, -1, 16'hA5C3, 16'h3C5A);
        check("R2", "clean frame halts", logic'(halts_seen == 0), 1'b1);

        cur_req = "R8";
        repeat (10) begin
            @(negedge clk);
            dlc_tx_bit = ~dlc_tx_bit; line_d_rx = ~line_d_rx; mode = mode ^ 3'b011;
        end
        mode = 3'b000;

        for (int m = 0; m < 8; m++) begin
            mode = m[2:0];
            cur_req = (m == 0) ? "R3" : (m[1] ? "R7" : (m[0] ? "R6" : "R5"));
            halts_seen = 0;
            frame(10, 3, 16'h0F35, 16'h5A96);
            check(cur_req, "halts per mismatching frame",
                  logic'(halts_seen == ((m == 0) ? 1 : 0)), 1'b1);
        end

        cur_req = "R4";
        mode = 3'b000;
        halts_seen = 0;
        frame(8, 1, 16'h00FF, 16'h00AA);
        check("R4", "halt then idle frame", logic'(halts_seen == 1), 1'b1);

        cur_req = "R9";
        halts_seen = 0;
        frame(10, 2, 16'h1234, 16'hFFFF);
        frame(10, 5, 16'h4321, 16'h0000);
        check("R9", "one halt per frame", logic'(halts_seen == 2), 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule